// File: doc/BRIEF.md
# Duplicated address tag checker

The block keeps six pairs of address tags for a prefetch unit. Two pairs belong to port A and four to port B. Each pair holds two copies of the same 32-byte-aligned address, a primary and a duplicate. While a pair is marked valid, the two copies are compared on every cycle. If they differ, the block raises an error event for the port that owns the pair, and that port's sticky error flag is set.

Software controls the block through a small register window. The window holds a control word, an alternate-address register, one write address shared by all primary tags, one shared by all duplicate tags, and a flag register that is cleared by writing 1.

Writing mode 5 together with key 5h enables a diagnostic mode. In that mode software can load each copy of the selected pair on its own. It can then fire a one-shot trigger that compares both copies against the alternate address. This proves that the comparator can detect a mismatch. Leaving the mode wipes every tag and every valid bit.

Top module: `dup_tag_checker`

## Requirements
- R1: The diagnostic mode is active, and `diag_active` is 1, only while the control register (address 0) holds mode 5 in bits [3:0] and key 5h in bits [7:4]. Any other pair of values, including the disabling pair mode 0 / key Ah, leaves the mode inactive. The buffer select is held in bits [10:8] of the same register.
- R2: Outside the diagnostic mode, a pulse on `load_en[i]` loads both copies of set i from `pf_addr` and marks the set valid. Load pulses are ignored while the diagnostic mode is active.
- R3: When a valid set holds two different copies, `tag_mismatch` shows the owning port in the same cycle, and that port's `tag_err` bit is set on the next clock edge. This happens in any mode. An invalid set never raises an event. Sets 0 and 1 belong to port A (bit 0); sets 2 to 5 belong to port B (bit 1).
- R4: A write to address 2 (primary) or address 3 (duplicate) reaches only the set chosen by the buffer select, and only in the diagnostic mode. Outside the diagnostic mode, and for select values 6 and 7, such writes are ignored. Reading address 2 or 3 returns the selected set's primary or duplicate copy, or 0 for select values 6 and 7. Reading address 1 returns the alternate address.
- R5: Writing the control register with bit 16 set, while in the diagnostic mode, fires a compare one cycle later. The alternate address (address 1) is compared with both copies of the selected set. If exactly one copy matches, the owning port's `tag_err` bit is set. If both copies match, or neither does, no flag is set.
- R6: Bits [4:0] of the alternate address, of loaded tags and of written tags are stored and compared as 0.
- R7: Writing the flag register (address 4) with bit 0 set clears port A's flag, and with bit 1 set clears port B's flag. The other port's flag is unaffected. A new error in the same cycle as a clear wins, and the flag stays 1.
- R8: Writing a control value that leaves the diagnostic mode clears all tags and all valid bits on the same clock edge.
- R9: Loading tag values while the trigger is 0 produces no compare result. The trigger acts once per write and does not repeat.
- R10: After reset, all flags, tags, valid bits and control fields are 0 and the diagnostic mode is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | N_A+N_B | Per-set load strobe from the prefetch logic |
| pf_addr | input | ADDR_W | Prefetch address loaded into both copies |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write address |
| wr_data | input | ADDR_W | Register write data |
| rd_addr | input | REG_AW | Register read address |
| rd_data | output | ADDR_W | Register read data (combinational) |
| diag_active | output | 1 | Diagnostic mode enabled |
| tag_mismatch | output | 2 | Per-port continuous compare event (bit 0 port A, bit 1 port B) |
| tag_err | output | 2 | Per-port sticky address-tag error flag |

## Verification
The bench uses the default parameters: 32-bit addresses, a 5-bit dropped offset, and a 2 + 4 set split. With these defaults the select values 6 and 7 exist but map to no set, so the ignored-select path can be exercised. Every set on both ports is reached by a table-driven diagnostic compare. The table covers a primary-only match, a duplicate-only match, a match on both copies, a match on neither, and a match that holds only after the low offset bits are dropped. Directed tests then load a set through the prefetch strobe and corrupt one copy to drive the continuous compare. They also cover clear-versus-set priority, per-port clearing, and the wipe on exit.

// File: rtl/dup_tag_checker.sv
module dup_tag_checker #(
  parameter int ADDR_W   = 32,
  parameter int LOW_BITS = 5,
  parameter int N_A      = 2,
  parameter int N_B      = 4,
  parameter int REG_AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_A+N_B-1:0]   load_en,
  input  logic [ADDR_W-1:0]    pf_addr,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [ADDR_W-1:0]    rd_data,
  output logic                 diag_active,
  output logic [1:0]           tag_mismatch,
  output logic [1:0]           tag_err
);
  localparam int N     = N_A + N_B;
  localparam int SEL_W = $clog2(N);
  localparam int TRIG_BIT = 16;
  localparam logic [REG_AW-1:0] RA_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] RA_ALT  = REG_AW'(1);
  localparam logic [REG_AW-1:0] RA_PRIM = REG_AW'(2);
  localparam logic [REG_AW-1:0] RA_DUP  = REG_AW'(3);
  localparam logic [REG_AW-1:0] RA_ERR  = REG_AW'(4);
  localparam logic [ADDR_W-1:0] KEEP = {{(ADDR_W-LOW_BITS){1'b1}}, {LOW_BITS{1'b0}}};

  logic [3:0]        mode_q, key_q;
  logic [SEL_W-1:0]  sel_q;
  logic              trig_q;
  logic [ADDR_W-1:0] alt_q;
  logic [ADDR_W-1:0] prim_q [N];
  logic [ADDR_W-1:0] dup_q  [N];
  logic [N-1:0]      valid_q;
  logic [N-1:0]      pair_bad;
  logic [ADDR_W-1:0] sel_prim, sel_dup;
  logic [1:0]        diag_set;

  wire ctrl_wr  = wr_en && wr_addr == RA_CTRL;
  wire alt_wr   = wr_en && wr_addr == RA_ALT;
  wire prim_wr  = wr_en && wr_addr == RA_PRIM;
  wire dup_wr   = wr_en && wr_addr == RA_DUP;
  wire err_wr   = wr_en && wr_addr == RA_ERR;
  wire new_diag = wr_data[3:0] == 4'h5 && wr_data[7:4] == 4'h5;
  wire leave    = diag_active && ctrl_wr && !new_diag;
  wire sel_ok   = 32'(sel_q) < N;
  wire sel_a    = 32'(sel_q) < N_A;

  assign diag_active = mode_q == 4'h5 && key_q == 4'h5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      key_q  <= '0;
      sel_q  <= '0;
      trig_q <= 1'b0;
      alt_q  <= '0;
    end else begin
      trig_q <= ctrl_wr && new_diag && wr_data[TRIG_BIT];
      if (ctrl_wr) begin
        mode_q <= wr_data[3:0];
        key_q  <= wr_data[7:4];
        sel_q  <= wr_data[8 +: SEL_W];
      end
      if (alt_wr) alt_q <= wr_data & KEEP;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_set
    wire hit = sel_q == SEL_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prim_q[g]  <= '0;
        dup_q[g]   <= '0;
        valid_q[g] <= 1'b0;
      end else if (leave) begin
        prim_q[g]  <= '0;
        dup_q[g]   <= '0;
        valid_q[g] <= 1'b0;
      end else if (diag_active) begin
        if (prim_wr && hit) prim_q[g] <= wr_data & KEEP;
        if (dup_wr && hit)  dup_q[g]  <= wr_data & KEEP;
      end else if (load_en[g]) begin
        prim_q[g]  <= pf_addr & KEEP;
        dup_q[g]   <= pf_addr & KEEP;
        valid_q[g] <= 1'b1;
      end
    end
    assign pair_bad[g] = valid_q[g] && prim_q[g] != dup_q[g];
  end

  assign tag_mismatch = {|pair_bad[N-1:N_A], |pair_bad[N_A-1:0]};

  always_comb begin
    sel_prim = '0;
    sel_dup  = '0;
    for (int i = 0; i < N; i++)
      if (sel_q == SEL_W'(i)) begin
        sel_prim = prim_q[i];
        sel_dup  = dup_q[i];
      end
  end

  wire diag_hit = trig_q && diag_active && sel_ok &&
                  ((alt_q == sel_prim) != (alt_q == sel_dup));
  assign diag_set = {diag_hit && !sel_a, diag_hit && sel_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_err <= '0;
    else        tag_err <= tag_mismatch | diag_set | (tag_err & ~(err_wr ? wr_data[1:0] : 2'b00));
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[3:0]        = mode_q;
        rd_data[7:4]        = key_q;
        rd_data[8 +: SEL_W] = sel_q;
      end
      RA_ALT:  rd_data = alt_q;
      RA_PRIM: rd_data = sel_prim;
      RA_DUP:  rd_data = sel_dup;
      RA_ERR:  rd_data[1:0] = tag_err;
      default: rd_data = '0;
    endcase
  end
endmodule

module dup_tag_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [ADDR_W-1:0] wr_data,
  input logic              diag_active,
  input logic [1:0]        tag_mismatch,
  input logic [1:0]        tag_err
);
  wire clr_a = wr_en && wr_addr == REG_AW'(4) && wr_data[0];
  wire clr_b = wr_en && wr_addr == REG_AW'(4) && wr_data[1];

  a_r8_exit_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(diag_active) |-> tag_mismatch == 2'b00);

  a_r8_normal_pairs_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_active |-> tag_mismatch == 2'b00);

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tag_mismatch != 2'b00 |=> (tag_err & $past(tag_mismatch)) == $past(tag_mismatch));

  a_r7_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_err[0] && !clr_a) |=> tag_err[0]);

  a_r7_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_err[1] && !clr_b) |=> tag_err[1]);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_mismatch[0] && clr_a) |=> tag_err[0]);
endmodule

bind dup_tag_checker dup_tag_checker_sva #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_sva (.*);

// File: tb/test_dup_tag_checker.sv
`timescale 1ns/1ps
module test_dup_tag_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  load_en = '0;
  logic [31:0] pf_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        diag_active;
  logic [1:0]  tag_mismatch, tag_err;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dup_tag_checker i_dup_tag_checker (.*);

  localparam logic [31:0] DIAG = 32'h55;
  localparam logic [31:0] OFF  = 32'hA0;
  localparam logic [31:0] TRIG = 32'h1_0000;
  localparam int NV = 8;
  localparam logic [2:0]  V_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd2};
  localparam logic [31:0] V_ALT [NV] = '{32'h1000, 32'h40, 32'h100, 32'h1E5, 32'h300, 32'hFFFF_FFE0, 32'h100, 32'h20};
  localparam logic [31:0] V_PRI [NV] = '{32'h1000, 32'h80, 32'h100, 32'h1FF, 32'h500, 32'h0, 32'h100, 32'h20};
  localparam logic [31:0] V_DUP [NV] = '{32'h2000, 32'h40, 32'h100, 32'h1E0, 32'h600, 32'hFFFF_FFFF, 32'h200, 32'h40};
  localparam logic [1:0]  V_ERR [NV] = '{2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b10};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic load(input int s, input logic [31:0] a);
    @(negedge clk);
    load_en = 6'(1 << s); pf_addr = a;
    @(negedge clk);
    load_en = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 flags", 32'(tag_err), 0);
    check("R10 diag", 32'(diag_active), 0);
    rd(3'd0, d); check("R10 ctrl", d, 0);
    rd(3'd2, d); check("R10 prim", d, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] ctl;
      ctl = DIAG | (32'(V_SEL[i]) << 8);
      wr(3'd0, ctl);
      wr(3'd1, V_ALT[i]);
      wr(3'd2, V_PRI[i]);
      wr(3'd3, V_DUP[i]);
      check("R9 preload no result", 32'(tag_err), 0);
      rd(3'd2, d);
      check("R4 R6 prim readback", d, V_SEL[i] < 6 ? V_PRI[i] & 32'hFFFF_FFE0 : 0);
      rd(3'd1, d);
      check("R6 alt readback", d, V_ALT[i] & 32'hFFFF_FFE0);
      wr(3'd0, ctl | TRIG);
      @(negedge clk);
      check("R5 compare result", 32'(tag_err), 32'(V_ERR[i]));
      wr(3'd4, 32'h3);
      check("R7 clear both", 32'(tag_err), 0);
    end
    wr(3'd0, OFF);

    wr(3'd0, 32'h45);
    check("R1 wrong key", 32'(diag_active), 0);
    wr(3'd2, 32'h500);
    rd(3'd2, d); check("R4 write outside diag ignored", d, 0);

    load(1, 32'h1234);
    wr(3'd0, OFF | 32'h100);
    rd(3'd2, d); check("R2 R6 load prim", d, 32'h1220);
    rd(3'd3, d); check("R2 load dup", d, 32'h1220);
    check("R3 equal copies no event", 32'(tag_mismatch), 0);

    wr(3'd0, DIAG | 32'h100);
    check("R1 diag on", 32'(diag_active), 1);
    load(1, 32'h7000);
    rd(3'd2, d); check("R2 load ignored in diag", d, 32'h1220);

    wr(3'd3, 32'h9990);
    check("R3 mismatch event port A", 32'(tag_mismatch), 1);
    @(negedge clk);
    check("R3 flag from event", 32'(tag_err), 1);
    wr(3'd4, 32'h1);
    check("R7 set beats clear", 32'(tag_err), 1);
    wr(3'd3, 32'h1220);
    check("R3 event gone", 32'(tag_mismatch), 0);
    wr(3'd4, 32'h1);
    check("R7 clear A", 32'(tag_err), 0);

    wr(3'd0, DIAG | 32'h300);
    wr(3'd1, 32'h800);
    wr(3'd2, 32'h800);
    wr(3'd3, 32'h0);
    check("R3 invalid set no event", 32'(tag_mismatch), 0);
    wr(3'd0, DIAG | 32'h300 | TRIG);
    @(negedge clk);
    check("R5 port B set", 32'(tag_err), 2);
    wr(3'd0, DIAG);
    wr(3'd2, 32'h800);
    wr(3'd3, 32'h0);
    wr(3'd0, DIAG | TRIG);
    @(negedge clk);
    check("R5 both ports", 32'(tag_err), 3);
    wr(3'd4, 32'h2);
    check("R7 clear B only", 32'(tag_err), 1);
    wr(3'd4, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 trigger one shot", 32'(tag_err), 0);

    wr(3'd0, OFF);
    check("R1 disabled", 32'(diag_active), 0);
    rd(3'd2, d); check("R8 tags wiped", d, 0);
    wr(3'd0, DIAG | 32'h100);
    rd(3'd2, d); check("R8 set1 prim wiped", d, 0);
    rd(3'd3, d); check("R8 set1 dup wiped", d, 0);
    wr(3'd2, 32'h40);
    check("R8 valid wiped", 32'(tag_mismatch), 0);
    @(negedge clk);
    check("R8 no flag", 32'(tag_err), 0);

    finish_run();
  end
endmodule